// File: doc/BRIEF.md
# PCI Slot Hotplug Event Controller

This block keeps the hotplug bookkeeping for a bank of PCI slots and tells the operating system about changes through one general-purpose event bit. The platform reports slot changes on per-slot request lines. An insert request can carry a power-on flag, and a power-on insertion is recorded silently. The block also sees a per-slot mask of devices that cannot be hot-removed, and a mask of the slots that are physically occupied. Software reads and writes a small word-addressed register window. It sees which slots may need a device check, which removals are still waiting, and which slots are removable. It acknowledges a removal by writing the eject register, and the block answers with a one-cycle eject pulse on that slot.

The insertion view is not a latched event. It is made up at read time as "present and hotpluggable", so a slot that is occupied but not hotpluggable never shows in it. A platform reset first works off every outstanding removal, lowest slot first and one slot per cycle, with an eject pulse for each. It then rebuilds the present and removable masks from the occupancy and fixed-device inputs. A power-on reset clears everything and performs the rebuild only.

Top module: `hp_slot_ctrl`

## Requirements
- R1: A read at offset 0x00 returns the bitwise AND of the present mask and the removable mask. A hot or cold insert request sets the slot's present bit.
- R2: A read at offset 0x04 returns the pending-removal mask. A remove request sets the slot's bit there.
- R3: A read at offset 0x08 returns zero. A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 also returns zero.
- R4: A read at offset 0x0C returns the removable mask. After a rebuild this mask is the inverse of the fixed-device mask.
- R5: A write at offset 0x08 acts on the lowest set bit of the data only. It clears that slot's pending-removal bit and clears its present bit, unless the slot is fixed. On the next cycle, and for that cycle only, it drives the eject output with that single bit.
- R6: A write of zero at offset 0x08 changes no state and produces no eject pulse.
- R7: A hot insert or any remove sets event status bit 1. An insert request flagged as power-on leaves the status unchanged.
- R8: The event status at offset 0x10 reads as bit 1, and writing a one to bit 1 clears it. Writing a zero there leaves it unchanged. The event enable at offset 0x14 is an 8-bit plain read/write register.
- R9: The interrupt output is high exactly while status bit 1 and enable bit 1 are both set. It follows a register write on the next cycle.
- R10: When a request arrives in the same cycle as a software clear of the status bit, the status bit stays set.
- R11: A platform reset clears status and enable. It then ejects the pending slots one per cycle, lowest first, with one pulse each, until none are left. Finally it sets the present mask to the occupancy input and the removable mask to the inverse of the fixed mask.
- R12: While the power-on reset is asserted, all masks, the interrupt and the eject output are zero. One cycle after its release, the masks are rebuilt as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| plat_rst | input | 1 | Platform reset request: flush removals, then rebuild |
| io_rd | input | 1 | Register read strobe |
| io_wr | input | 1 | Register write strobe |
| io_off | input | 5 | Byte offset within the register window |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, combinational, zero when not reading |
| ins_req | input | NSLOT | Per-slot insert request |
| ins_cold | input | 1 | Marks this cycle's insert requests as power-on insertions |
| rem_req | input | NSLOT | Per-slot remove request |
| fixed_mask | input | NSLOT | Slots holding devices that cannot be hot-removed |
| occupied | input | NSLOT | Slots physically occupied, used by the rebuild |
| sci | output | 1 | Level event interrupt |
| eject_pulse | output | NSLOT | One-cycle per-slot eject strobe |

## Verification
The hardest state to reach is a platform-reset flush with several removals still pending. Getting there takes a sequence of remove requests that software only partly acknowledges, and the stimulus must stay away from the lowest pending slot. The bench builds this state on purpose. It raises removals on several slots, ejects a lower one with a multi-bit write, and adds one more removal in the same cycle as a status clear. It then checks the order of the eject pulses cycle by cycle, and checks the rebuilt masks once the flush ends.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int REG_W  = 32;
    localparam int OFF_W  = 5;
    localparam int GPE_W  = 8;
    localparam int HP_BIT = 1;

    localparam logic [OFF_W-1:0] OFF_INS  = 5'h00;
    localparam logic [OFF_W-1:0] OFF_DOWN = 5'h04;
    localparam logic [OFF_W-1:0] OFF_EJ   = 5'h08;
    localparam logic [OFF_W-1:0] OFF_RMV  = 5'h0C;
    localparam logic [OFF_W-1:0] OFF_STS  = 5'h10;
    localparam logic [OFF_W-1:0] OFF_EN   = 5'h14;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_BUILD = 2'd2
    } core_st_t;

    typedef struct packed {
        logic ej;
        logic sts;
        logic en;
    } wr_strb_t;
endpackage

// File: rtl/hp_regif.sv
module hp_regif
    import hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic [OFF_W-1:0] io_off,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [NSLOT-1:0] present,
    input  logic [NSLOT-1:0] down,
    input  logic [NSLOT-1:0] hp_en,
    input  logic [GPE_W-1:0] gpe_sts,
    input  logic [GPE_W-1:0] gpe_en,
    output wr_strb_t         strb,
    output logic [REG_W-1:0] io_rdata
);
    logic [REG_W-1:0] mux;

    always_comb begin
        case (io_off)
            OFF_INS:  mux = REG_W'(present & hp_en);
            OFF_DOWN: mux = REG_W'(down);
            OFF_RMV:  mux = REG_W'(hp_en);
            OFF_STS:  mux = REG_W'(gpe_sts);
            OFF_EN:   mux = REG_W'(gpe_en);
            default:  mux = '0;
        endcase
    end

    assign io_rdata = io_rd ? mux : '0;

    always_comb begin
        strb.ej  = io_wr && (io_off == OFF_EJ);
        strb.sts = io_wr && (io_off == OFF_STS);
        strb.en  = io_wr && (io_off == OFF_EN);
    end
endmodule

// File: rtl/hp_gpe.sv
module hp_gpe
    import hp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             evt,
    input  logic             sts_wr,
    input  logic             en_wr,
    input  logic [GPE_W-1:0] wdata,
    output logic [GPE_W-1:0] gpe_sts,
    output logic [GPE_W-1:0] gpe_en,
    output logic             sts_hp,
    output logic             sci
);
    logic             sts_q;
    logic [GPE_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sts_q <= 1'b0;
            en_q  <= '0;
        end else begin
            if (en_wr)
                en_q <= wdata;
            if (evt)
                sts_q <= 1'b1;
            else if (sts_wr && wdata[HP_BIT])
                sts_q <= 1'b0;
        end
    end

    assign gpe_sts = GPE_W'(sts_q) << HP_BIT;
    assign gpe_en  = en_q;
    assign sts_hp  = sts_q;
    assign sci     = sts_q & en_q[HP_BIT];
endmodule

// File: rtl/hp_slot_core.sv
module hp_slot_core
    import hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             plat_rst,
    input  logic [NSLOT-1:0] ins_req,
    input  logic             ins_cold,
    input  logic [NSLOT-1:0] rem_req,
    input  logic [NSLOT-1:0] fixed_mask,
    input  logic [NSLOT-1:0] occupied,
    input  logic             ej_wr,
    input  logic [NSLOT-1:0] ej_data,
    output logic [NSLOT-1:0] present,
    output logic [NSLOT-1:0] down,
    output logic [NSLOT-1:0] hp_en,
    output logic [NSLOT-1:0] eject_pulse,
    output logic             busy,
    output logic             hot_evt
);
    core_st_t         st;
    logic [NSLOT-1:0] ej_low;
    logic [NSLOT-1:0] dn_low;
    logic [NSLOT-1:0] ej_clr;

    assign ej_low = ej_data & (~ej_data + NSLOT'(1));
    assign dn_low = down & (~down + NSLOT'(1));
    assign ej_clr = ej_wr ? ej_low : '0;

    assign busy    = (st != ST_RUN);
    assign hot_evt = (st == ST_RUN) && !plat_rst &&
                     (((|ins_req) && !ins_cold) || (|rem_req));

    always_ff @(posedge clk) begin
        if (rst) begin
            present     <= '0;
            down        <= '0;
            hp_en       <= '0;
            eject_pulse <= '0;
            st          <= ST_BUILD;
        end else if (plat_rst) begin
            eject_pulse <= '0;
            st          <= ST_FLUSH;
        end else begin
            case (st)
                ST_FLUSH: begin
                    if (down == '0) begin
                        eject_pulse <= '0;
                        st          <= ST_BUILD;
                    end else begin
                        down        <= down & ~dn_low;
                        present     <= present & ~(dn_low & ~fixed_mask);
                        eject_pulse <= dn_low;
                    end
                end
                ST_BUILD: begin
                    present     <= occupied;
                    hp_en       <= ~fixed_mask;
                    eject_pulse <= '0;
                    st          <= ST_RUN;
                end
                default: begin
                    eject_pulse <= ej_clr;
                    present     <= (present & ~(ej_clr & ~fixed_mask)) | ins_req;
                    down        <= (down & ~ej_clr) | rem_req;
                end
            endcase
        end
    end
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             plat_rst,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [OFF_W-1:0] io_off,
    input  logic [REG_W-1:0] io_wdata,
    output logic [REG_W-1:0] io_rdata,
    input  logic [NSLOT-1:0] ins_req,
    input  logic             ins_cold,
    input  logic [NSLOT-1:0] rem_req,
    input  logic [NSLOT-1:0] fixed_mask,
    input  logic [NSLOT-1:0] occupied,
    output logic             sci,
    output logic [NSLOT-1:0] eject_pulse
);
    wr_strb_t         strb;
    logic [NSLOT-1:0] present;
    logic [NSLOT-1:0] down;
    logic [NSLOT-1:0] hp_en;
    logic [GPE_W-1:0] gpe_sts;
    logic [GPE_W-1:0] gpe_en;
    logic             sts_hp;
    logic             busy;
    logic             hot_evt;

    hp_regif #(.NSLOT(NSLOT)) u_regif (
        .io_off   (io_off),
        .io_rd    (io_rd),
        .io_wr    (io_wr && !busy),
        .present  (present),
        .down     (down),
        .hp_en    (hp_en),
        .gpe_sts  (gpe_sts),
        .gpe_en   (gpe_en),
        .strb     (strb),
        .io_rdata (io_rdata)
    );

    hp_slot_core #(.NSLOT(NSLOT)) u_core (
        .clk         (clk),
        .rst         (rst),
        .plat_rst    (plat_rst),
        .ins_req     (ins_req),
        .ins_cold    (ins_cold),
        .rem_req     (rem_req),
        .fixed_mask  (fixed_mask),
        .occupied    (occupied),
        .ej_wr       (strb.ej),
        .ej_data     (io_wdata[NSLOT-1:0]),
        .present     (present),
        .down        (down),
        .hp_en       (hp_en),
        .eject_pulse (eject_pulse),
        .busy        (busy),
        .hot_evt     (hot_evt)
    );

    hp_gpe u_gpe (
        .clk     (clk),
        .rst     (rst),
        .clr     (plat_rst),
        .evt     (hot_evt),
        .sts_wr  (strb.sts),
        .en_wr   (strb.en),
        .wdata   (io_wdata[GPE_W-1:0]),
        .gpe_sts (gpe_sts),
        .gpe_en  (gpe_en),
        .sts_hp  (sts_hp),
        .sci     (sci)
    );
endmodule

// File: rtl/hp_slot_chk.sv
module hp_slot_chk
    import hp_pkg::*;
#(
    parameter int NSLOT = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             plat_rst,
    input logic             io_rd,
    input logic             io_wr,
    input logic [OFF_W-1:0] io_off,
    input logic [REG_W-1:0] io_wdata,
    input logic [REG_W-1:0] io_rdata,
    input logic [NSLOT-1:0] ins_req,
    input logic             ins_cold,
    input logic [NSLOT-1:0] rem_req,
    input logic             sts_hp,
    input logic             busy,
    input logic [NSLOT-1:0] eject_pulse
);
    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eject_pulse)); // R5

    AST_PULSE_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (eject_pulse != '0) |=> ((eject_pulse & $past(eject_pulse)) == '0)); // R11

    AST_ZERO_EJECT: assert property (@(posedge clk) disable iff (rst)
        (!busy && !plat_rst && io_wr && io_off == OFF_EJ && io_wdata == '0)
        |=> (eject_pulse == '0)); // R6

    AST_COLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && !sts_hp && ins_cold && rem_req == '0) |=> !sts_hp); // R7

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !plat_rst && rem_req != '0) |=> sts_hp); // R10

    AST_FEATURE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_off == OFF_EJ) |-> (io_rdata == '0)); // R3
endmodule

bind hp_slot_ctrl hp_slot_chk #(.NSLOT(NSLOT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .plat_rst    (plat_rst),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_off      (io_off),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .ins_req     (ins_req),
    .ins_cold    (ins_cold),
    .rem_req     (rem_req),
    .sts_hp      (sts_hp),
    .busy        (busy),
    .eject_pulse (eject_pulse)
);

// File: tb/sim_hp_slot_ctrl.sv
`timescale 1ns/1ps
module sim_hp_slot_ctrl;
    localparam int NSLOT = 32;

    typedef struct packed {
        logic [31:0] ins;
        logic        cold;
        logic [31:0] rem;
        logic [31:0] exp_ins;
        logic [31:0] exp_down;
        logic        exp_sts;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{32'h0000_0010, 1'b1, 32'h0,          32'h0000_0012, 32'h0,          1'b0},
        '{32'h0000_0100, 1'b0, 32'h0,          32'h0000_0112, 32'h0,          1'b1},
        '{32'h0,         1'b0, 32'h0000_0010,  32'h0000_0112, 32'h0000_0010,  1'b1},
        '{32'h0000_0001, 1'b0, 32'h0,          32'h0000_0112, 32'h0000_0010,  1'b1},
        '{32'h0,         1'b0, 32'h0000_0300,  32'h0000_0112, 32'h0000_0310,  1'b1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             plat_rst = 1'b0;
    logic             io_rd = 1'b0;
    logic             io_wr = 1'b0;
    logic [4:0]       io_off = '0;
    logic [31:0]      io_wdata = '0;
    logic [31:0]      io_rdata;
    logic [NSLOT-1:0] ins_req = '0;
    logic             ins_cold = 1'b0;
    logic [NSLOT-1:0] rem_req = '0;
    logic [NSLOT-1:0] fixed_mask = 32'h0000_0001;
    logic [NSLOT-1:0] occupied = 32'h0000_0003;
    logic             sci;
    logic [NSLOT-1:0] eject_pulse;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    hp_slot_ctrl #(.NSLOT(NSLOT)) u0 (
        .clk(clk), .rst(rst), .plat_rst(plat_rst), .io_rd(io_rd), .io_wr(io_wr),
        .io_off(io_off), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ins_req(ins_req), .ins_cold(ins_cold), .rem_req(rem_req),
        .fixed_mask(fixed_mask), .occupied(occupied), .sci(sci),
        .eject_pulse(eject_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] off, output logic [31:0] d);
        io_off = off;
        io_rd  = 1'b1;
        #1;
        d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic wr(input logic [4:0] off, input logic [31:0] d);
        @(negedge clk);
        io_off = off; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; io_wdata = '0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R12: state held at zero during power-on reset
        repeat (3) @(negedge clk);
        rd(5'h00, rv); check("R12 ins in reset", rv, 32'h0);
        rd(5'h0C, rv); check("R12 rmv in reset", rv, 32'h0);
        check("R12 sci in reset", 32'(sci), 32'h0);
        check("R12 eject in reset", eject_pulse, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        rd(5'h00, rv); check("R12 rebuild ins", rv, 32'h0000_0002);
        rd(5'h0C, rv); check("R4 rebuild rmv", rv, 32'hFFFF_FFFE);

        // R1 R2 R7: request vectors
        foreach (VECS[i]) begin
            @(negedge clk);
            ins_req = VECS[i].ins; ins_cold = VECS[i].cold; rem_req = VECS[i].rem;
            @(negedge clk);
            ins_req = '0; ins_cold = 1'b0; rem_req = '0;
            rd(5'h00, rv); check("R1 insertion view", rv, VECS[i].exp_ins);
            rd(5'h04, rv); check("R2 pending removals", rv, VECS[i].exp_down);
            rd(5'h10, rv); check("R7 event status", rv, VECS[i].exp_sts ? 32'h2 : 32'h0);
            wr(5'h10, 32'h2);
            rd(5'h10, rv); check("R8 status w1c", rv, 32'h0);
        end

        // R3: feature and undecoded offsets
        rd(5'h08, rv); check("R3 feature read", rv, 32'h0);
        rd(5'h18, rv); check("R3 undecoded read", rv, 32'h0);

        // R5: multi-bit eject acts on slot 4 only
        wr(5'h08, 32'h0000_0310);
        check("R5 eject pulse", eject_pulse, 32'h0000_0010);
        rd(5'h04, rv); check("R5 down after eject", rv, 32'h0000_0300);
        rd(5'h00, rv); check("R5 present cleared", rv, 32'h0000_0102);
        @(negedge clk);
        check("R5 pulse one cycle", eject_pulse, 32'h0);

        // R6: zero eject does nothing
        wr(5'h08, 32'h0);
        check("R6 no pulse", eject_pulse, 32'h0);
        rd(5'h04, rv); check("R6 down unchanged", rv, 32'h0000_0300);

        // R8 R9: enable and interrupt level
        wr(5'h14, 32'h0000_00A5);
        rd(5'h14, rv); check("R8 enable rw", rv, 32'h0000_00A5);
        wr(5'h14, 32'h0000_0002);
        check("R9 sci off with status clear", 32'(sci), 32'h0);
        @(negedge clk); rem_req = 32'h0000_0400;
        @(negedge clk); rem_req = '0;
        check("R9 sci on", 32'(sci), 32'h1);
        wr(5'h10, 32'h0);
        rd(5'h10, rv); check("R8 write zero keeps status", rv, 32'h2);
        wr(5'h14, 32'h0);
        check("R9 sci off by enable", 32'(sci), 32'h0);
        wr(5'h14, 32'h2);
        wr(5'h10, 32'h2);
        check("R9 sci off by clear", 32'(sci), 32'h0);

        // R10: request in the same cycle as a status clear
        @(negedge clk);
        rem_req = 32'h0000_0800; io_off = 5'h10; io_wdata = 32'h2; io_wr = 1'b1;
        @(negedge clk);
        rem_req = '0; io_wr = 1'b0; io_wdata = '0;
        rd(5'h10, rv); check("R10 set wins", rv, 32'h2);
        rd(5'h04, rv); check("R2 down before flush", rv, 32'h0000_0F00);

        // R11: platform reset flush then rebuild
        occupied = 32'h0000_0021;
        @(negedge clk); plat_rst = 1'b1;
        @(negedge clk); plat_rst = 1'b0;
        rd(5'h10, rv); check("R11 status cleared", rv, 32'h0);
        rd(5'h14, rv); check("R11 enable cleared", rv, 32'h0);
        for (int s = 8; s < 12; s++) begin
            @(negedge clk);
            check("R11 flush order", eject_pulse, 32'h1 << s);
        end
        @(negedge clk);
        check("R11 flush done", eject_pulse, 32'h0);
        @(negedge clk);
        rd(5'h04, rv); check("R11 down empty", rv, 32'h0);
        rd(5'h00, rv); check("R11 present rebuilt", rv, 32'h0000_0020);
        rd(5'h0C, rv); check("R11 rmv rebuilt", rv, 32'hFFFF_FFFE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule